// File: doc/BRIEF.md
# Cross-Clock Snapshot Pulse Generator

This block produces the parallel-load enable for a chain of serially scanned copy registers. The copy registers run on a slow serial clock. The state they copy changes on a separate core clock. The enable rises when the core clock falls, which is the moment the core state has just settled. It drops again when the serial clock next falls. If the core clock falls while the serial clock is low, the enable window holds exactly one rising edge of the serial clock, and the copy registers take their snapshot on that edge.

Each clock drives its own single-bit state register. The set side toggles on a core-clock falling edge. The clear side copies the set side on a serial-clock falling edge. The enable is the XOR of the two bits. Both clocks are assumed to be slow and controlled by a host, so no synchronizer stages are added between the domains.

Top module: `snap_pulse_gen`

## Requirements
- R1: When load_en is low and rst_n is high, a falling edge of cpu_clk drives load_en high.
- R2: While load_en is high, the next falling edge of spi_clk drives load_en low.
- R3: When the pulse starts while spi_clk is low, exactly one rising edge of spi_clk occurs while load_en is high. Whatever the phase, no pulse ever contains more than one such edge.
- R4: While rst_n is low, load_en is low whatever the clocks do. Reset acts asynchronously and clears both internal bits, so after release load_en stays low until a cpu_clk falling edge.
- R5: Further cpu_clk falling edges while load_en is high keep it high and do not extend or restart the pulse. The pulse still ends at the next spi_clk falling edge.
- R6: While load_en is low, spi_clk edges and rising edges of cpu_clk leave it low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_clk | input | 1 | Core clock; its falling edge opens the snapshot window |
| spi_clk | input | 1 | Serial scan clock; its falling edge closes the window |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_en | output | 1 | Parallel-load enable for the copy registers |

## Verification
The bench varies the phase between the two clocks. It drives core falls while the serial clock is high and while it is low, several core falls inside one pulse, and serial activity while the enable is idle. A design that cleared on the serial rising edge would frame no capture edge at all. A design that re-armed on every core fall would stretch the window or emit a second pulse. The bench also applies reset in the middle of a pulse and toggles both clocks during reset. A design whose reset cleared only one of the two bits would show a stray pulse after release.

// File: rtl/snap_pkg.sv
package snap_pkg;
    // state of the core-clock side: a toggle bit that arms a window
    typedef struct packed {
        logic arm;
    } set_state_t;

    // state of the serial-clock side: a copy of the arm bit
    typedef struct packed {
        logic seen;
    } clr_state_t;

    localparam set_state_t SET_RESET = '{arm: 1'b0};
    localparam clr_state_t CLR_RESET = '{seen: 1'b0};
endpackage

// File: rtl/snap_set_side.sv
module snap_set_side
    import snap_pkg::*;
(
    input  logic cpu_clk,
    input  logic rst_n,
    input  logic seen_i,
    output logic arm_o
);
    set_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // open a window only when none is open (arm equals its copy)
        if (st_q.arm == seen_i) begin
            st_d.arm = ~st_q.arm;
        end
    end

    always_ff @(negedge cpu_clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= SET_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign arm_o = st_q.arm;
endmodule

// File: rtl/snap_clr_side.sv
module snap_clr_side
    import snap_pkg::*;
(
    input  logic spi_clk,
    input  logic rst_n,
    input  logic arm_i,
    output logic seen_o
);
    clr_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.seen = arm_i;
    end

    always_ff @(negedge spi_clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= CLR_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign seen_o = st_q.seen;
endmodule

// File: rtl/snap_pulse_gen.sv
module snap_pulse_gen (
    input  logic cpu_clk,
    input  logic spi_clk,
    input  logic rst_n,
    output logic load_en
);
    logic arm_q;
    logic seen_q;

    snap_set_side u_set (
        .cpu_clk (cpu_clk),
        .rst_n   (rst_n),
        .seen_i  (seen_q),
        .arm_o   (arm_q)
    );

    snap_clr_side u_clr (
        .spi_clk (spi_clk),
        .rst_n   (rst_n),
        .arm_i   (arm_q),
        .seen_o  (seen_q)
    );

    // window is open while the two domain bits disagree
    assign load_en = arm_q ^ seen_q;
endmodule

// File: rtl/snap_pulse_chk.sv
module snap_pulse_chk #(
    parameter int CNT_W = 16
) (
    input logic cpu_clk,
    input logic spi_clk,
    input logic rst_n,
    input logic load_en
);
    logic [CNT_W-1:0] spi_fall_cnt;
    logic [CNT_W-1:0] cpu_fall_cnt;
    logic [CNT_W-1:0] cpu_epoch;
    logic             cpu_any;
    logic [CNT_W-1:0] rst_cnt = '0;

    always @(posedge rst_n) rst_cnt <= rst_cnt + 1'b1;

    always_ff @(negedge spi_clk or negedge rst_n) begin
        if (!rst_n) spi_fall_cnt <= '0;
        else        spi_fall_cnt <= spi_fall_cnt + 1'b1;
    end

    always_ff @(negedge cpu_clk or negedge rst_n) begin
        if (!rst_n) begin
            cpu_fall_cnt <= '0;
            cpu_epoch    <= '0;
            cpu_any      <= 1'b0;
        end else begin
            cpu_fall_cnt <= cpu_fall_cnt + 1'b1;
            cpu_epoch    <= spi_fall_cnt;
            cpu_any      <= 1'b1;
        end
    end

    // R1/R2: at a serial rise the window is open exactly when a core fall
    // came after the most recent serial fall
    assert_level_model_R1: assert property (@(posedge spi_clk) disable iff (!rst_n)
        load_en == (cpu_any && (cpu_epoch == spi_fall_cnt)))
        else $error("load_en disagrees with edge ordering");

    // R3: an open window sees one serial rise unless a new core fall or reset intervened
    assert_one_capture_R3: assert property (@(posedge spi_clk) disable iff (!rst_n)
        load_en |=> (!load_en || (cpu_fall_cnt != $past(cpu_fall_cnt))
                     || (rst_cnt != $past(rst_cnt))))
        else $error("two capture edges in one window");

    // R5: only a serial fall (or reset) may close a window between core falls
    assert_hold_open_R5: assert property (@(negedge cpu_clk) disable iff (!rst_n)
        load_en |=> (load_en || (spi_fall_cnt != $past(spi_fall_cnt))
                     || (rst_cnt != $past(rst_cnt))))
        else $error("window closed without serial fall");

    // R4: low during reset
    always @(posedge spi_clk) begin
        if (rst_n === 1'b0) begin
            assert_reset_low_R4: assert (load_en === 1'b0)
                else $error("load_en high during reset");
        end
    end
endmodule

bind snap_pulse_gen snap_pulse_chk u_chk (
    .cpu_clk (cpu_clk),
    .spi_clk (spi_clk),
    .rst_n   (rst_n),
    .load_en (load_en)
);

// File: tb/sim_snap_pulse_gen.sv
module sim_snap_pulse_gen;
    logic tb_clk  = 1'b0;
    logic cpu_clk = 1'b0;
    logic spi_clk = 1'b0;
    logic rst_n   = 1'b0;
    logic load_en;

    always #4 tb_clk = ~tb_clk;   // 125 MHz step clock

    snap_pulse_gen u0 (
        .cpu_clk (cpu_clk),
        .spi_clk (spi_clk),
        .rst_n   (rst_n),
        .load_en (load_en)
    );

    int   checks = 0;
    int   fails  = 0;
    int   cyc    = 0;
    logic m      = 1'b0;   // expected load_en
    int   rises  = 0;      // serial rises inside current window
    logic from_low = 1'b0; // window opened while spi_clk low

    function automatic logic f_next(logic cur, logic cpu_fell, logic spi_fell);
        if (spi_fell) return 1'b0;
        if (cpu_fell) return 1'b1;
        return cur;
    endfunction

    task automatic chk(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: load_en=%0b expected %0b", req, act, exp);
        end
    endtask

    task automatic step(bit tc, bit ts, bit rst_val);
        bit    cf, sf, sr;
        string tag;
        @(posedge tb_clk);
        cf = tc && cpu_clk;
        sf = ts && spi_clk;
        sr = ts && !spi_clk;
        rst_n = rst_val;
        if (tc) cpu_clk = ~cpu_clk;
        if (ts) spi_clk = ~spi_clk;
        tag = "R6";
        if (!rst_val) begin
            m   = 1'b0;
            tag = "R4";
        end else begin
            if (cf) tag = m ? "R5" : "R1";
            if (sf) tag = "R2";
            if (sr && m) begin
                rises++;
                tag = "R3";
            end
            if (sf && m && from_low) begin
                checks++;
                if (rises != 1) begin
                    fails++;
                    $display("FAIL R3: captures=%0d expected 1", rises);
                end
            end
            if (cf && !m) begin
                from_low = !spi_clk;
                rises    = 0;
            end
            m = f_next(m, cf, sf);
        end
        @(negedge tb_clk);
        chk(tag, load_en, m);
    endtask

    always @(posedge tb_clk) begin
        cyc++;
        if (cyc > 150000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: cycles=%0d expected below 150000", cyc);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        // R4: reset with both clocks moving
        step(0, 0, 0);
        step(1, 0, 0);
        step(1, 0, 0);
        step(0, 1, 0);
        step(0, 1, 0);
        step(0, 0, 1);   // release: still low (R4/R6)
        step(0, 1, 1);   // R6: serial edges while idle
        step(0, 1, 1);
        step(1, 0, 1);   // core rise: no effect (R6)
        // R1, R5, R3, R2
        step(1, 0, 1);   // core fall opens
        step(1, 0, 1);
        step(1, 0, 1);   // second core fall keeps open (R5)
        step(0, 1, 1);   // serial rise inside window (R3)
        step(1, 0, 1);
        step(1, 0, 1);   // another core fall while open (R5)
        step(0, 1, 1);   // serial fall closes (R2)
        // core fall while serial high
        step(0, 1, 1);
        step(1, 0, 1);
        step(1, 0, 1);   // opens (R1)
        step(0, 1, 1);   // closes at serial fall (R2)
        // reset mid-window
        step(1, 0, 1);
        step(1, 0, 1);
        step(0, 0, 0);   // R4
        step(0, 0, 1);
        step(0, 1, 1);
        step(0, 1, 1);   // stays low after reset (R4)
        // random phases
        for (int i = 0; i < 40000; i++) begin
            int r;
            r = $urandom % 16;
            if (($urandom % 700) == 0) step(0, 0, 0);
            else if (r < 5)            step(1, 0, 1);
            else if (r < 10)           step(0, 1, 1);
            else                       step(0, 0, 1);
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule